// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Unit

This block holds four counters behind one small register bus. Three of them are reloadable down-counters. Two are 16 bits wide and one is 32 bits wide. Each has its own interrupt line, which it raises on underflow. The fourth counter is 40 bits wide, counts up without stopping and has no interrupt. It is read through two registers: one holds the low 32 bits, and the other holds the top 8 bits together with the run enable.

The unit has no clock dividers. Two single-cycle tick inputs stand in for the slow and fast reference clocks. Each down-counter picks one of the two ticks through a bit in its control register. In periodic mode a channel reloads from its load register on underflow. In free mode it wraps to all ones. An interrupt stays asserted until software writes any value to the channel's clear register.

Top module: `tmr_unit`

## Requirements
- R1: After reset, every readable register reads zero and all three interrupt lines are low.
- R2: A write to a channel's load register (offset 0x0 from its base; bases 0x00, 0x20, 0x80) sets both the load and the value register from the write data. The new value is readable on the next cycle. A load write takes priority over a count tick in the same cycle.
- R3: A down-counter changes only when its enable (control bit 7) is set and its selected tick is high. It then decrements by one. When disabled it holds its value.
- R4: In periodic mode (control bit 6 = 1), the tick that finds the value at zero is an underflow. It reloads the value from the load register, so a load of N gives one underflow every N+1 ticks.
- R5: In free mode (control bit 6 = 0), an underflow wraps the value to all ones of the channel width (0xFFFF or 0xFFFFFFFF), and counting continues from there.
- R6: An underflow sets the channel's interrupt, which stays high until a write of any data to the clear register (offset 0xC). If an underflow and a clear fall in the same cycle, the interrupt stays set.
- R7: Control bit 3 = 1 makes the channel count on the fast tick instead of the slow tick.
- R8: The 16-bit channels keep only the low 16 bits of a written load. Their load and value registers read zero in bits 31:16.
- R9: The 40-bit counter increments on each fast tick while its enable is set. The enable is bit 8 of the register at 0x64. The low 32 bits read at 0x60. Bits 39:32 read in bits 7:0 of 0x64, with the enable read back in bit 8. Writes to 0x60 are ignored.
- R10: Control reads return only bits 7, 6 and 3. Writes to value registers are ignored. Clear registers and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | Slow reference count pulse |
| fast_tick | input | 1 | Fast reference count pulse |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 3 | Pending underflow interrupt per reloadable channel |

## Verification
The assertions check several rules on every cycle. A load write lands in the value register on the next edge. With no tick and no write, every count holds. An interrupt only rises after the value sat at zero, and it stays up until its own clear register is written. The free-running counter steps by exactly one per enabled fast tick. The bench scenarios cover what needs a sequence of events: reload periods for several load values, wrap to all ones at both widths, the choice between slow and fast tick, a clear in the same cycle as an underflow, the split read of the 40-bit count, and reads of masked or unmapped registers.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BUS_W       = 32;
    localparam int ADDR_W      = 8;
    localparam int NUM_RELOAD  = 3;
    localparam int SMALL_CNT_W = 16;
    localparam int LARGE_CNT_W = 32;
    localparam int FREE_CNT_W  = 40;
    localparam int CHAN_IDX_W  = $clog2(NUM_RELOAD);

    // control bit positions
    localparam int CTL_EN_BIT   = 7;
    localparam int CTL_PER_BIT  = 6;
    localparam int CTL_FAST_BIT = 3;
    localparam int FREE_EN_BIT  = 8;

    // register offsets inside a channel window
    localparam logic [3:0] OFS_LOAD  = 4'h0;
    localparam logic [3:0] OFS_VALUE = 4'h4;
    localparam logic [3:0] OFS_CTRL  = 4'h8;
    localparam logic [3:0] OFS_CLEAR = 4'hC;

    localparam logic [ADDR_W-1:0] FREE_LO_ADDR = 8'h60;
    localparam logic [ADDR_W-1:0] FREE_HI_ADDR = 8'h64;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_LOAD,
        RS_VALUE,
        RS_CTRL,
        RS_FREE_LO,
        RS_FREE_HI
    } rd_sel_e;

    function automatic logic [ADDR_W-1:0] chan_base(input int idx);
        case (idx)
            0:       return 8'h00;
            1:       return 8'h20;
            default: return 8'h80;
        endcase
    endfunction

    function automatic int chan_width(input int idx);
        return (idx == NUM_RELOAD - 1) ? LARGE_CNT_W : SMALL_CNT_W;
    endfunction
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
(
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    output logic [NUM_RELOAD-1:0] wr_load,
    output logic [NUM_RELOAD-1:0] wr_ctrl,
    output logic [NUM_RELOAD-1:0] wr_clear,
    output logic                  wr_free_hi,
    output rd_sel_e               rd_sel,
    output logic [CHAN_IDX_W-1:0] rd_chan
);
    always_comb begin
        wr_load    = '0;
        wr_ctrl    = '0;
        wr_clear   = '0;
        wr_free_hi = bus_we && (bus_addr == FREE_HI_ADDR);
        rd_sel     = RS_NONE;
        rd_chan    = '0;
        if (bus_addr == FREE_LO_ADDR) rd_sel = RS_FREE_LO;
        if (bus_addr == FREE_HI_ADDR) rd_sel = RS_FREE_HI;
        for (int i = 0; i < NUM_RELOAD; i++) begin
            if (bus_addr[ADDR_W-1:4] == chan_base(i) >> 4) begin
                rd_chan = CHAN_IDX_W'(i);
                case (bus_addr[3:0])
                    OFS_LOAD: begin
                        rd_sel     = RS_LOAD;
                        wr_load[i] = bus_we;
                    end
                    OFS_VALUE: rd_sel = RS_VALUE;
                    OFS_CTRL: begin
                        rd_sel     = RS_CTRL;
                        wr_ctrl[i] = bus_we;
                    end
                    OFS_CLEAR: wr_clear[i] = bus_we;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_reload_chan.sv
module tmr_reload_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic             fast_tick,
    input  logic             wr_load,
    input  logic             wr_ctrl,
    input  logic             wr_clear,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] load_rd,
    output logic [BUS_W-1:0] value_rd,
    output logic [BUS_W-1:0] ctrl_rd,
    output logic             irq
);
    typedef struct packed {
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] value;
        logic             en;
        logic             periodic;
        logic             fast;
        logic             irq;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     tick;
    logic     underflow;

    always_comb begin
        st_d      = st_q;
        tick      = st_q.fast ? fast_tick : slow_tick;
        underflow = 1'b0;
        if (wr_ctrl) begin
            st_d.en       = wdata[CTL_EN_BIT];
            st_d.periodic = wdata[CTL_PER_BIT];
            st_d.fast     = wdata[CTL_FAST_BIT];
        end
        if (wr_load) begin
            st_d.load  = wdata[CNT_W-1:0];
            st_d.value = wdata[CNT_W-1:0];
        end else if (st_q.en && tick) begin
            if (st_q.value == '0) begin
                underflow  = 1'b1;
                st_d.value = st_q.periodic ? st_q.load : '1;
            end else begin
                st_d.value = st_q.value - 1'b1;
            end
        end
        if (wr_clear)  st_d.irq = 1'b0;
        if (underflow) st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        load_rd               = BUS_W'(st_q.load);
        value_rd              = BUS_W'(st_q.value);
        ctrl_rd               = '0;
        ctrl_rd[CTL_EN_BIT]   = st_q.en;
        ctrl_rd[CTL_PER_BIT]  = st_q.periodic;
        ctrl_rd[CTL_FAST_BIT] = st_q.fast;
        irq                   = st_q.irq;
    end
endmodule

// File: rtl/tmr_free_cnt.sv
module tmr_free_cnt
    import tmr_pkg::*;
#(
    parameter int CNT_W = FREE_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fast_tick,
    input  logic             wr_hi,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] lo_rd,
    output logic [BUS_W-1:0] hi_rd,
    output logic [CNT_W-1:0] cnt,
    output logic             en
);
    localparam int HI_W = CNT_W - BUS_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en;
    } free_st_t;

    free_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hi) st_d.en = wdata[FREE_EN_BIT];
        if (st_q.en && fast_tick) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        lo_rd              = st_q.cnt[BUS_W-1:0];
        hi_rd              = '0;
        hi_rd[HI_W-1:0]    = st_q.cnt[CNT_W-1:BUS_W];
        hi_rd[FREE_EN_BIT] = st_q.en;
        cnt                = st_q.cnt;
        en                 = st_q.en;
    end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  slow_tick,
    input  logic                  fast_tick,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata,
    output logic [NUM_RELOAD-1:0] irq
);
    logic [NUM_RELOAD-1:0] wr_load, wr_ctrl, wr_clear;
    logic                  wr_free_hi;
    rd_sel_e               rd_sel;
    logic [CHAN_IDX_W-1:0] rd_chan;

    logic [BUS_W-1:0] load_rd  [NUM_RELOAD];
    logic [BUS_W-1:0] value_rd [NUM_RELOAD];
    logic [BUS_W-1:0] ctrl_rd  [NUM_RELOAD];
    logic [NUM_RELOAD-1:0][BUS_W-1:0] chan_val_w;

    logic [BUS_W-1:0]      free_lo_rd, free_hi_rd;
    logic [FREE_CNT_W-1:0] free_cnt_w;
    logic                  free_en_w;

    tmr_decode u_decode (
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .wr_load   (wr_load),
        .wr_ctrl   (wr_ctrl),
        .wr_clear  (wr_clear),
        .wr_free_hi(wr_free_hi),
        .rd_sel    (rd_sel),
        .rd_chan   (rd_chan)
    );

    for (genvar i = 0; i < NUM_RELOAD; i++) begin : g_chan
        tmr_reload_chan #(.CNT_W(chan_width(i))) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .slow_tick(slow_tick),
            .fast_tick(fast_tick),
            .wr_load  (wr_load[i]),
            .wr_ctrl  (wr_ctrl[i]),
            .wr_clear (wr_clear[i]),
            .wdata    (bus_wdata),
            .load_rd  (load_rd[i]),
            .value_rd (value_rd[i]),
            .ctrl_rd  (ctrl_rd[i]),
            .irq      (irq[i])
        );
        assign chan_val_w[i] = value_rd[i];
    end

    tmr_free_cnt #(.CNT_W(FREE_CNT_W)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast_tick(fast_tick),
        .wr_hi    (wr_free_hi),
        .wdata    (bus_wdata),
        .lo_rd    (free_lo_rd),
        .hi_rd    (free_hi_rd),
        .cnt      (free_cnt_w),
        .en       (free_en_w)
    );

    always_comb begin
        case (rd_sel)
            RS_LOAD:    bus_rdata = load_rd[rd_chan];
            RS_VALUE:   bus_rdata = value_rd[rd_chan];
            RS_CTRL:    bus_rdata = ctrl_rd[rd_chan];
            RS_FREE_LO: bus_rdata = free_lo_rd;
            RS_FREE_HI: bus_rdata = free_hi_rd;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
    import tmr_pkg::*;
(
    input logic                             clk,
    input logic                             rst_n,
    input logic                             slow_tick,
    input logic                             fast_tick,
    input logic [ADDR_W-1:0]                bus_addr,
    input logic                             bus_we,
    input logic [BUS_W-1:0]                 bus_wdata,
    input logic [NUM_RELOAD-1:0]            irq,
    input logic [NUM_RELOAD-1:0][BUS_W-1:0] chan_val,
    input logic [FREE_CNT_W-1:0]            free_cnt,
    input logic                             free_en
);
    for (genvar i = 0; i < NUM_RELOAD; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] BASE = chan_base(i);
        localparam logic [BUS_W-1:0]  MASK =
            (chan_width(i) >= BUS_W) ? '1 : BUS_W'((64'd1 << chan_width(i)) - 1);

        p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
            bus_we && bus_addr == (BASE | ADDR_W'(OFS_LOAD))
            |=> chan_val[i] == ($past(bus_wdata) & MASK));

        p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] && !(bus_we && bus_addr == (BASE | ADDR_W'(OFS_CLEAR)))
            |=> irq[i]);

        p_irq_from_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) |-> $past(chan_val[i]) == '0);
    end

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !slow_tick && !fast_tick && !bus_we |=> $stable(chan_val));

    p_free_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fast_tick && free_en |=> free_cnt == $past(free_cnt) + 1'b1);

    p_free_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_tick |=> $stable(free_cnt));
endmodule

bind tmr_unit tmr_unit_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_tick(slow_tick),
    .fast_tick(fast_tick),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .irq      (irq),
    .chan_val (chan_val_w),
    .free_cnt (free_cnt_w),
    .free_en  (free_en_w)
);

// File: tb/tmr_unit_tb_top.sv
module tmr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        fast_tick = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    tmr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [31:0] load;
        logic [15:0] ticks;
        logic [31:0] exp_val;
        logic        exp_irq;
    } vec_t;

    // periodic channel 1: load N, apply ticks, expected value and interrupt (R4)
    localparam vec_t VECS [5] = '{
        '{load: 32'd5,  ticks: 16'd3,  exp_val: 32'd2, exp_irq: 1'b0},
        '{load: 32'd5,  ticks: 16'd6,  exp_val: 32'd5, exp_irq: 1'b1},
        '{load: 32'd4,  ticks: 16'd7,  exp_val: 32'd2, exp_irq: 1'b1},
        '{load: 32'd0,  ticks: 16'd3,  exp_val: 32'd0, exp_irq: 1'b1},
        '{load: 32'd10, ticks: 16'd10, exp_val: 32'd0, exp_irq: 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d,
                       input logic s, input logic f);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; slow_tick = s; fast_tick = f;
        @(posedge clk);
        #1;
        bus_we = 1'b0; slow_tick = 1'b0; fast_tick = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic slow(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 8'h00, 32'h0, 1'b1, 1'b0);
    endtask

    task automatic fast(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 8'h00, 32'h0, 1'b0, 1'b1);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1 ch1 load", 8'h00, 32'h0);
        rd_chk("R1 ch2 value", 8'h24, 32'h0);
        rd_chk("R1 ch3 ctrl", 8'h88, 32'h0);
        rd_chk("R1 free lo", 8'h60, 32'h0);
        rd_chk("R1 free hi", 8'h64, 32'h0);
        check("R1 irq", {29'b0, irq}, 32'h0);

        // R4 vector table on channel 1, periodic and enabled
        foreach (VECS[v]) begin
            wr(8'h0C, 32'h0);
            wr(8'h08, 32'hC0);
            wr(8'h00, VECS[v].load);
            rd_chk("R2 load sets value", 8'h04, VECS[v].load);
            slow(int'(VECS[v].ticks));
            rd_chk("R4 periodic value", 8'h04, VECS[v].exp_val);
            check("R4 periodic irq", {31'b0, irq[0]}, {31'b0, VECS[v].exp_irq});
        end

        // R3 disabled channel holds
        wr(8'h08, 32'h40);
        wr(8'h00, 32'd7);
        slow(3);
        rd_chk("R3 disabled hold", 8'h04, 32'd7);

        // R10 value write ignored, control masking
        wr(8'h04, 32'h55);
        rd_chk("R10 value write ignored", 8'h04, 32'd7);
        rd_chk("R10 ctrl readback", 8'h08, 32'h40);
        wr(8'h08, 32'hFF);
        rd_chk("R10 ctrl masked", 8'h08, 32'hC8);
        wr(8'h08, 32'h0);

        // R8 16-bit truncation
        wr(8'h20, 32'hABCD1234);
        rd_chk("R8 load truncated", 8'h20, 32'h1234);
        rd_chk("R8 value truncated", 8'h24, 32'h1234);

        // R7 fast tick select
        wr(8'h28, 32'h88);
        slow(2);
        rd_chk("R7 slow ignored", 8'h24, 32'h1234);
        fast(2);
        rd_chk("R7 fast counts", 8'h24, 32'h1232);
        wr(8'h28, 32'h0);

        // R5 free mode wrap, 32-bit
        wr(8'h88, 32'h80);
        wr(8'h80, 32'd1);
        slow(2);
        rd_chk("R5 wrap 32", 8'h84, 32'hFFFFFFFF);
        check("R6 irq on underflow", {31'b0, irq[2]}, 32'h1);
        slow(1);
        rd_chk("R5 continue after wrap", 8'h84, 32'hFFFFFFFE);

        // R5 free mode wrap, 16-bit
        wr(8'h08, 32'h80);
        wr(8'h00, 32'd0);
        slow(1);
        rd_chk("R5 wrap 16", 8'h04, 32'h0000FFFF);
        wr(8'h08, 32'h0);

        // R6 sticky and clear
        slow(3);
        check("R6 sticky", {31'b0, irq[2]}, 32'h1);
        wr(8'h8C, 32'hDEADBEEF);
        check("R6 clear any value", {31'b0, irq[2]}, 32'h0);
        wr(8'h0C, 32'h0);
        wr(8'h08, 32'hC0);
        wr(8'h00, 32'd0);
        cyc(1'b1, 8'h0C, 32'h0, 1'b1, 1'b0);
        check("R6 underflow beats clear", {31'b0, irq[0]}, 32'h1);
        wr(8'h0C, 32'h0);
        check("R6 clear after", {31'b0, irq[0]}, 32'h0);
        wr(8'h08, 32'h0);

        // R9 free-running counter
        fast(3);
        rd_chk("R9 disabled hold", 8'h60, 32'h0);
        wr(8'h64, 32'h100);
        fast(5);
        rd_chk("R9 low count", 8'h60, 32'd5);
        rd_chk("R9 high and enable", 8'h64, 32'h100);
        wr(8'h64, 32'h0);
        fast(2);
        rd_chk("R9 stopped", 8'h60, 32'd5);
        wr(8'h60, 32'h99);
        rd_chk("R9 low write ignored", 8'h60, 32'd5);

        // R10 unmapped and clear reads
        rd_chk("R10 unmapped 0x10", 8'h10, 32'h0);
        rd_chk("R10 unmapped 0x44", 8'h44, 32'h0);
        rd_chk("R10 clear reads zero", 8'h0C, 32'h0);

        finish_run();
    end
endmodule